// File: doc/BRIEF.md
# Register Tag Rewriting Engine

This block repairs register dependences after a mispredicted branch when the instructions past the branch's reconvergence point are kept and not squashed. A low-confidence branch starts the tracking of architectural destinations written by the renamer. When the instruction at the predicted convergence PC reaches rename, the block first snapshots the current (wrong-path) rename map. When the branch then resolves as mispredicted, the snapshot is compared with the correct-path map. Registers that were written during tracking and whose physical tag differs form a bitmask. Each set bit yields a rewrite pair (old physical tag to new physical tag).

While it walks the pairs, one per cycle, the block holds the front end with `stall`. For each pair it replaces matching source tags in the younger entries of a small issue-queue tag store and every matching slot of the younger map checkpoints. A replaced operand takes its ready bit from the physical-register ready vector. A correctly predicted branch costs nothing. The block holds the issue-queue source tags and the map checkpoints. The rest of the pipeline writes these through plain write ports and reads them back through index-addressed read ports.

The controller is a state machine:
- IDLE goes to TRACK on a low-confidence branch.
- TRACK goes to ARMED when the convergence PC is renamed, and back to IDLE if the branch resolves first.
- ARMED goes to IDLE on a correct resolution. On a misprediction it goes to WALK when the mask is non-empty and to DONE when it is empty.
- WALK stays in WALK until the last pair has been applied, then goes to DONE.
- DONE goes to IDLE after one cycle.

Top module: `tagfix_engine`

## Requirements
- R1: After reset `stall` and `done` are low, and every issue-queue field, age and checkpoint slot reads back as zero.
- R2: A branch with `br_lowconf` low starts no tracking: a later convergence rename and mispredicted resolution produce no stall, no done and no tag change.
- R3: The checkpoint is `map_now` as sampled in the cycle the convergence PC is renamed (before that rename), and the convergence instruction's own destination is not marked as written. Later changes to `map_now` do not alter it.
- R4: Only architectural registers that were both written during tracking and differ between the checkpoint and `fix_map` are rewritten.
- R5: Each pair replaces every issue-queue source tag equal to the checkpoint tag with the `fix_map` tag, in entries whose age is strictly greater than `conv_age`.
- R6: Issue-queue entries and checkpoints with age less than or equal to `conv_age` are never changed by a rewrite.
- R7: A replaced issue-queue operand takes its ready bit from `preg_ready` at the new tag; operands that are not replaced keep theirs.
- R8: Each pair replaces every matching slot (any architectural index, multiple slots allowed) of younger map checkpoints.
- R9: One pair is applied per cycle, in ascending architectural-register order, and `stall` is high for exactly as many cycles as the mask has set bits, starting the cycle after the mispredicted resolution.
- R10: `done` is a one-cycle pulse in the cycle after the last pair is applied, and the block is then idle.
- R11: A correctly predicted resolution (`resolve_mispred` low) gives no stall and no done.
- R12: A mispredicted resolution with an empty mask raises `done` in the next cycle with no stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | A branch is renamed this cycle |
| br_lowconf | input | 1 | That branch is low-confidence |
| ren_valid | input | 1 | An instruction is renamed this cycle |
| ren_pc | input | PC_W | PC of the renamed instruction |
| ren_dst_valid | input | 1 | Renamed instruction writes a register |
| ren_dst_areg | input | AREG_W | Its architectural destination |
| conv_pc | input | PC_W | Predicted convergence PC |
| map_now | input | NAREG*PTAG_W | Current rename map, slot i at bits [i*PTAG_W +: PTAG_W] |
| resolve_valid | input | 1 | Tracked branch resolves this cycle |
| resolve_mispred | input | 1 | It was mispredicted |
| fix_map | input | NAREG*PTAG_W | Correct-path map at the convergence point |
| conv_age | input | AGE_W | Age of the convergence point |
| preg_ready | input | 2**PTAG_W | Ready bit per physical register |
| iq_wr_en | input | 1 | Issue-queue entry write |
| iq_wr_idx | input | log2(IQ_N) | Entry index |
| iq_wr_age | input | AGE_W | Entry age |
| iq_wr_src0 | input | PTAG_W | Source 0 tag |
| iq_wr_src1 | input | PTAG_W | Source 1 tag |
| iq_wr_rdy0 | input | 1 | Source 0 ready |
| iq_wr_rdy1 | input | 1 | Source 1 ready |
| iq_rd_idx | input | log2(IQ_N) | Entry read index |
| iq_rd_src0 | output | PTAG_W | Source 0 tag read |
| iq_rd_src1 | output | PTAG_W | Source 1 tag read |
| iq_rd_rdy0 | output | 1 | Source 0 ready read |
| iq_rd_rdy1 | output | 1 | Source 1 ready read |
| ck_wr_en | input | 1 | Checkpoint write |
| ck_wr_idx | input | log2(CK_N) | Checkpoint index |
| ck_wr_age | input | AGE_W | Checkpoint age |
| ck_wr_map | input | NAREG*PTAG_W | Checkpoint map |
| ck_rd_idx | input | log2(CK_N) | Checkpoint read index |
| ck_rd_map | output | NAREG*PTAG_W | Checkpoint map read |
| stall | output | 1 | Front-end hold during the walk |
| done | output | 1 | Walk finished pulse |

## Verification
The assertions assume the following of the pipeline around the block:
- Nothing writes the issue queue or the checkpoints while `stall` is high.
- Rename and branch resolution do not fall in the same cycle.
- The correct-path tags of one recovery are disjoint from its wrong-path tags, so a pair never feeds a later pair.

The stimulus keeps to this. It loads the stores only while idle, separates rename, convergence and resolution by at least one cycle, and draws wrong-path and correct-path tags from separate ranges.

// File: rtl/tfx_pkg.sv
package tfx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_TRACK,
        S_ARMED,
        S_WALK,
        S_DONE
    } tfx_state_e;
endpackage

// File: rtl/tfx_ctrl.sv
module tfx_ctrl
    import tfx_pkg::*;
#(
    parameter int NAREG  = 8,
    parameter int PTAG_W = 5,
    parameter int AGE_W  = 6,
    parameter int PC_W   = 16,
    parameter int AREG_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    br_valid,
    input  logic                    br_lowconf,
    input  logic                    ren_valid,
    input  logic [PC_W-1:0]         ren_pc,
    input  logic                    ren_dst_valid,
    input  logic [AREG_W-1:0]       ren_dst_areg,
    input  logic [PC_W-1:0]         conv_pc,
    input  logic [NAREG*PTAG_W-1:0] map_now,
    input  logic                    resolve_valid,
    input  logic                    resolve_mispred,
    input  logic [NAREG*PTAG_W-1:0] fix_map,
    input  logic [AGE_W-1:0]        conv_age,
    output logic                    rw_valid,
    output logic [PTAG_W-1:0]       rw_from,
    output logic [PTAG_W-1:0]       rw_to,
    output logic [AGE_W-1:0]        rw_age,
    output logic                    stall,
    output logic                    done
);
    localparam int MAP_W = NAREG * PTAG_W;

    tfx_state_e        st_q, st_d;
    logic [NAREG-1:0]  written_q, mask_q, diff_w, hit_w;
    logic [MAP_W-1:0]  ck_q, fix_q;
    logic [AGE_W-1:0]  age_q;
    logic [AREG_W-1:0] pick;
    logic              at_conv, last_pair;

    assign at_conv   = ren_valid && (ren_pc == conv_pc);
    assign hit_w     = written_q & diff_w;
    assign last_pair = (mask_q & (mask_q - 1'b1)) == '0;

    for (genvar g = 0; g < NAREG; g++) begin : g_diff
        assign diff_w[g] = ck_q[g*PTAG_W +: PTAG_W] != fix_map[g*PTAG_W +: PTAG_W];
    end

    always_comb begin
        pick = '0;
        for (int i = NAREG - 1; i >= 0; i--) begin
            if (mask_q[i]) pick = AREG_W'(i);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (br_valid && br_lowconf) st_d = S_TRACK;
            S_TRACK: begin
                if (resolve_valid) st_d = S_IDLE;
                else if (at_conv)  st_d = S_ARMED;
            end
            S_ARMED: begin
                if (resolve_valid) begin
                    if (!resolve_mispred) st_d = S_IDLE;
                    else if (|hit_w)      st_d = S_WALK;
                    else                  st_d = S_DONE;
                end
            end
            S_WALK:  if (last_pair) st_d = S_DONE;
            S_DONE:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written_q <= '0;
            mask_q    <= '0;
            ck_q      <= '0;
            fix_q     <= '0;
            age_q     <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: if (br_valid && br_lowconf) written_q <= '0;
                S_TRACK: begin
                    if (at_conv) ck_q <= map_now;
                    else if (ren_valid && ren_dst_valid) written_q[ren_dst_areg] <= 1'b1;
                end
                S_ARMED: begin
                    if (resolve_valid && resolve_mispred) begin
                        mask_q <= hit_w;
                        fix_q  <= fix_map;
                        age_q  <= conv_age;
                    end
                end
                S_WALK:  mask_q[pick] <= 1'b0;
                S_DONE:  mask_q <= '0;
                default: mask_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        rw_valid = 1'b0;
        stall    = 1'b0;
        done     = 1'b0;
        unique case (st_q)
            S_WALK: begin
                rw_valid = 1'b1;
                stall    = 1'b1;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign rw_from = ck_q[pick*PTAG_W +: PTAG_W];
    assign rw_to   = fix_q[pick*PTAG_W +: PTAG_W];
    assign rw_age  = age_q;
endmodule

// File: rtl/tfx_iq.sv
module tfx_iq #(
    parameter int N      = 4,
    parameter int IDX_W  = 2,
    parameter int PTAG_W = 5,
    parameter int AGE_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [AGE_W-1:0]      wr_age,
    input  logic [PTAG_W-1:0]     wr_src0,
    input  logic [PTAG_W-1:0]     wr_src1,
    input  logic                  wr_rdy0,
    input  logic                  wr_rdy1,
    input  logic                  rw_valid,
    input  logic [PTAG_W-1:0]     rw_from,
    input  logic [PTAG_W-1:0]     rw_to,
    input  logic [AGE_W-1:0]      rw_age,
    input  logic [(1<<PTAG_W)-1:0] preg_ready,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [PTAG_W-1:0]     rd_src0,
    output logic [PTAG_W-1:0]     rd_src1,
    output logic                  rd_rdy0,
    output logic                  rd_rdy1
);
    localparam int NSRC = 2;

    logic [PTAG_W-1:0] src_q [N][NSRC];
    logic              rdy_q [N][NSRC];
    logic [AGE_W-1:0]  age_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < N; e++) begin
                age_q[e] <= '0;
                for (int s = 0; s < NSRC; s++) begin
                    src_q[e][s] <= '0;
                    rdy_q[e][s] <= 1'b0;
                end
            end
        end else begin
            for (int e = 0; e < N; e++) begin
                if (wr_en && (wr_idx == IDX_W'(e))) begin
                    age_q[e]    <= wr_age;
                    src_q[e][0] <= wr_src0;
                    src_q[e][1] <= wr_src1;
                    rdy_q[e][0] <= wr_rdy0;
                    rdy_q[e][1] <= wr_rdy1;
                end else if (rw_valid && (age_q[e] > rw_age)) begin
                    for (int s = 0; s < NSRC; s++) begin
                        if (src_q[e][s] == rw_from) begin
                            src_q[e][s] <= rw_to;
                            rdy_q[e][s] <= preg_ready[rw_to];
                        end
                    end
                end
            end
        end
    end

    assign rd_src0 = src_q[rd_idx][0];
    assign rd_src1 = src_q[rd_idx][1];
    assign rd_rdy0 = rdy_q[rd_idx][0];
    assign rd_rdy1 = rdy_q[rd_idx][1];
endmodule

// File: rtl/tfx_ckpt.sv
module tfx_ckpt #(
    parameter int N      = 2,
    parameter int IDX_W  = 1,
    parameter int NAREG  = 8,
    parameter int PTAG_W = 5,
    parameter int AGE_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [AGE_W-1:0]        wr_age,
    input  logic [NAREG*PTAG_W-1:0] wr_map,
    input  logic                    rw_valid,
    input  logic [PTAG_W-1:0]       rw_from,
    input  logic [PTAG_W-1:0]       rw_to,
    input  logic [AGE_W-1:0]        rw_age,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [NAREG*PTAG_W-1:0] rd_map
);
    logic [NAREG*PTAG_W-1:0] map_q [N];
    logic [AGE_W-1:0]        age_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < N; c++) begin
                map_q[c] <= '0;
                age_q[c] <= '0;
            end
        end else begin
            for (int c = 0; c < N; c++) begin
                if (wr_en && (wr_idx == IDX_W'(c))) begin
                    map_q[c] <= wr_map;
                    age_q[c] <= wr_age;
                end else if (rw_valid && (age_q[c] > rw_age)) begin
                    for (int a = 0; a < NAREG; a++) begin
                        if (map_q[c][a*PTAG_W +: PTAG_W] == rw_from)
                            map_q[c][a*PTAG_W +: PTAG_W] <= rw_to;
                    end
                end
            end
        end
    end

    assign rd_map = map_q[rd_idx];
endmodule

// File: rtl/tagfix_engine.sv
module tagfix_engine #(
    parameter int NAREG  = 8,
    parameter int PTAG_W = 5,
    parameter int AGE_W  = 6,
    parameter int PC_W   = 16,
    parameter int IQ_N   = 4,
    parameter int CK_N   = 2,
    localparam int AREG_W = (NAREG > 1) ? $clog2(NAREG) : 1,
    localparam int IQI_W  = (IQ_N > 1) ? $clog2(IQ_N) : 1,
    localparam int CKI_W  = (CK_N > 1) ? $clog2(CK_N) : 1,
    localparam int MAP_W  = NAREG * PTAG_W,
    localparam int NPREG  = 1 << PTAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic              br_lowconf,
    input  logic              ren_valid,
    input  logic [PC_W-1:0]   ren_pc,
    input  logic              ren_dst_valid,
    input  logic [AREG_W-1:0] ren_dst_areg,
    input  logic [PC_W-1:0]   conv_pc,
    input  logic [MAP_W-1:0]  map_now,
    input  logic              resolve_valid,
    input  logic              resolve_mispred,
    input  logic [MAP_W-1:0]  fix_map,
    input  logic [AGE_W-1:0]  conv_age,
    input  logic [NPREG-1:0]  preg_ready,
    input  logic              iq_wr_en,
    input  logic [IQI_W-1:0]  iq_wr_idx,
    input  logic [AGE_W-1:0]  iq_wr_age,
    input  logic [PTAG_W-1:0] iq_wr_src0,
    input  logic [PTAG_W-1:0] iq_wr_src1,
    input  logic              iq_wr_rdy0,
    input  logic              iq_wr_rdy1,
    input  logic [IQI_W-1:0]  iq_rd_idx,
    output logic [PTAG_W-1:0] iq_rd_src0,
    output logic [PTAG_W-1:0] iq_rd_src1,
    output logic              iq_rd_rdy0,
    output logic              iq_rd_rdy1,
    input  logic              ck_wr_en,
    input  logic [CKI_W-1:0]  ck_wr_idx,
    input  logic [AGE_W-1:0]  ck_wr_age,
    input  logic [MAP_W-1:0]  ck_wr_map,
    input  logic [CKI_W-1:0]  ck_rd_idx,
    output logic [MAP_W-1:0]  ck_rd_map,
    output logic              stall,
    output logic              done
);
    logic              rw_valid;
    logic [PTAG_W-1:0] rw_from, rw_to;
    logic [AGE_W-1:0]  rw_age;

    tfx_ctrl #(
        .NAREG(NAREG), .PTAG_W(PTAG_W), .AGE_W(AGE_W), .PC_W(PC_W), .AREG_W(AREG_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_lowconf(br_lowconf),
        .ren_valid(ren_valid), .ren_pc(ren_pc),
        .ren_dst_valid(ren_dst_valid), .ren_dst_areg(ren_dst_areg),
        .conv_pc(conv_pc), .map_now(map_now),
        .resolve_valid(resolve_valid), .resolve_mispred(resolve_mispred),
        .fix_map(fix_map), .conv_age(conv_age),
        .rw_valid(rw_valid), .rw_from(rw_from), .rw_to(rw_to), .rw_age(rw_age),
        .stall(stall), .done(done)
    );

    tfx_iq #(
        .N(IQ_N), .IDX_W(IQI_W), .PTAG_W(PTAG_W), .AGE_W(AGE_W)
    ) u_iq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(iq_wr_en), .wr_idx(iq_wr_idx), .wr_age(iq_wr_age),
        .wr_src0(iq_wr_src0), .wr_src1(iq_wr_src1),
        .wr_rdy0(iq_wr_rdy0), .wr_rdy1(iq_wr_rdy1),
        .rw_valid(rw_valid), .rw_from(rw_from), .rw_to(rw_to), .rw_age(rw_age),
        .preg_ready(preg_ready),
        .rd_idx(iq_rd_idx), .rd_src0(iq_rd_src0), .rd_src1(iq_rd_src1),
        .rd_rdy0(iq_rd_rdy0), .rd_rdy1(iq_rd_rdy1)
    );

    tfx_ckpt #(
        .N(CK_N), .IDX_W(CKI_W), .NAREG(NAREG), .PTAG_W(PTAG_W), .AGE_W(AGE_W)
    ) u_ckpt (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ck_wr_en), .wr_idx(ck_wr_idx), .wr_age(ck_wr_age), .wr_map(ck_wr_map),
        .rw_valid(rw_valid), .rw_from(rw_from), .rw_to(rw_to), .rw_age(rw_age),
        .rd_idx(ck_rd_idx), .rd_map(ck_rd_map)
    );
endmodule

// File: rtl/tfx_checker.sv
module tfx_checker #(
    parameter int NAREG = 8
) (
    input logic clk,
    input logic rst_n,
    input logic stall,
    input logic done,
    input logic resolve_valid,
    input logic resolve_mispred
);
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_len <= 0;
        else if (stall) run_len <= run_len + 1;
        else            run_len <= 0;
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && done));

    p_walk_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> done);

    p_walk_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(resolve_valid && resolve_mispred));

    p_done_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(stall) || $past(resolve_valid && resolve_mispred)));

    p_walk_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= NAREG);
endmodule

bind tagfix_engine tfx_checker #(.NAREG(NAREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .done(done),
    .resolve_valid(resolve_valid), .resolve_mispred(resolve_mispred)
);

// File: tb/sim_tagfix_engine.sv
`timescale 1ns/1ps
module sim_tagfix_engine;
    localparam int NA = 8, PW = 5, AW = 6, CW = 16, IQN = 4, CKN = 2;
    localparam int MW = NA * PW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic br_valid = 0, br_lowconf = 0, ren_valid = 0, ren_dst_valid = 0;
    logic [CW-1:0] ren_pc = '0, conv_pc = 16'h0040;
    logic [2:0] ren_dst_areg = '0;
    logic [MW-1:0] map_now = '0, fix_map = '0, ck_wr_map = '0, ck_rd_map;
    logic resolve_valid = 0, resolve_mispred = 0;
    logic [AW-1:0] conv_age = '0, iq_wr_age = '0, ck_wr_age = '0;
    logic [31:0] preg_ready = 32'hA5A5_3C3C;
    logic iq_wr_en = 0, iq_wr_rdy0 = 0, iq_wr_rdy1 = 0, ck_wr_en = 0;
    logic [1:0] iq_wr_idx = '0, iq_rd_idx = '0;
    logic [PW-1:0] iq_wr_src0 = '0, iq_wr_src1 = '0, iq_rd_src0, iq_rd_src1;
    logic iq_rd_rdy0, iq_rd_rdy1;
    logic [0:0] ck_wr_idx = '0, ck_rd_idx = '0;
    logic stall, done;

    tagfix_engine u0 (.*);

    always #2 clk = ~clk;

    int compared = 0, mismatched = 0;
    string cur_req = "R1";
    bit finished = 0;

    task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_state;   // 0 idle 1 track 2 armed 3 walk 4 done
    bit [7:0] m_written, m_mask;
    int m_ck[8], m_fix[8];
    int m_age;
    int m_src[4][2];
    bit m_rdy[4][2];
    int m_iqage[4];
    int m_cmap[2][8];
    int m_ckage[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_written = 0; m_mask = 0; m_age = 0;
            for (int i = 0; i < 8; i++) begin m_ck[i] = 0; m_fix[i] = 0; end
            for (int e = 0; e < 4; e++) begin
                m_iqage[e] = 0;
                for (int s = 0; s < 2; s++) begin m_src[e][s] = 0; m_rdy[e][s] = 0; end
            end
            for (int c = 0; c < 2; c++) begin
                m_ckage[c] = 0;
                for (int a = 0; a < 8; a++) m_cmap[c][a] = 0;
            end
        end else begin
            int nx, k, fr, to;
            bit [7:0] hit;
            nx = m_state; k = 0; fr = 0; to = 0;
            if (m_state == 3) begin
                for (int i = 7; i >= 0; i--) if (m_mask[i]) k = i;
                fr = m_ck[k]; to = m_fix[k];
            end
            for (int e = 0; e < 4; e++) begin
                if (iq_wr_en && iq_wr_idx == e) begin
                    m_iqage[e] = iq_wr_age;
                    m_src[e][0] = iq_wr_src0; m_src[e][1] = iq_wr_src1;
                    m_rdy[e][0] = iq_wr_rdy0; m_rdy[e][1] = iq_wr_rdy1;
                end else if (m_state == 3 && m_iqage[e] > m_age) begin
                    for (int s = 0; s < 2; s++)
                        if (m_src[e][s] == fr) begin m_src[e][s] = to; m_rdy[e][s] = preg_ready[to]; end
                end
            end
            for (int c = 0; c < 2; c++) begin
                if (ck_wr_en && ck_wr_idx == c) begin
                    m_ckage[c] = ck_wr_age;
                    for (int a = 0; a < 8; a++) m_cmap[c][a] = ck_wr_map[a*PW +: PW];
                end else if (m_state == 3 && m_ckage[c] > m_age) begin
                    for (int a = 0; a < 8; a++) if (m_cmap[c][a] == fr) m_cmap[c][a] = to;
                end
            end
            case (m_state)
                0: if (br_valid && br_lowconf) begin nx = 1; m_written = 0; end
                1: begin
                    if (resolve_valid) nx = 0;
                    else if (ren_valid && ren_pc == conv_pc) begin
                        nx = 2;
                        for (int i = 0; i < 8; i++) m_ck[i] = map_now[i*PW +: PW];
                    end else if (ren_valid && ren_dst_valid) m_written[ren_dst_areg] = 1;
                end
                2: if (resolve_valid) begin
                    if (!resolve_mispred) nx = 0;
                    else begin
                        hit = 0;
                        for (int i = 0; i < 8; i++) begin
                            m_fix[i] = fix_map[i*PW +: PW];
                            if (m_written[i] && m_ck[i] != m_fix[i]) hit[i] = 1;
                        end
                        m_mask = hit; m_age = conv_age;
                        nx = (hit != 0) ? 3 : 4;
                    end
                end
                3: begin m_mask[k] = 0; nx = (m_mask == 0) ? 4 : 3; end
                default: nx = 0;
            endcase
            m_state = nx;
        end
    end

    // per-clock comparison of the control outputs
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cmp(cur_req, {63'd0, stall}, {63'd0, m_state == 3});
            cmp(cur_req, {63'd0, done},  {63'd0, m_state == 4});
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [MW-1:0] pack(input int t[8]);
        logic [MW-1:0] r;
        for (int i = 0; i < 8; i++) r[i*PW +: PW] = PW'(t[i]);
        return r;
    endfunction

    task automatic check_stores(input string req);
        @(negedge clk); #0.1;
        for (int e = 0; e < 4; e++) begin
            iq_rd_idx = 2'(e); #0.1;
            cmp(req, 64'(iq_rd_src0), 64'(m_src[e][0]));
            cmp(req, 64'(iq_rd_src1), 64'(m_src[e][1]));
            cmp(req, 64'(iq_rd_rdy0), 64'(m_rdy[e][0]));
            cmp(req, 64'(iq_rd_rdy1), 64'(m_rdy[e][1]));
        end
        for (int c = 0; c < 2; c++) begin
            int t[8];
            ck_rd_idx = 1'(c); #0.1;
            for (int a = 0; a < 8; a++) t[a] = m_cmap[c][a];
            cmp(req, 64'(ck_rd_map), 64'(pack(t)));
        end
    endtask

    task automatic iq_put(input int idx, input int age, input int s0, input int s1, input bit r0, input bit r1);
        @(negedge clk);
        iq_wr_en = 1; iq_wr_idx = 2'(idx); iq_wr_age = AW'(age);
        iq_wr_src0 = PW'(s0); iq_wr_src1 = PW'(s1); iq_wr_rdy0 = r0; iq_wr_rdy1 = r1;
        @(negedge clk); iq_wr_en = 0;
    endtask

    task automatic ck_put(input int idx, input int age, input logic [MW-1:0] m);
        @(negedge clk);
        ck_wr_en = 1; ck_wr_idx = 1'(idx); ck_wr_age = AW'(age); ck_wr_map = m;
        @(negedge clk); ck_wr_en = 0;
    endtask

    task automatic branch(input bit lc);
        @(negedge clk); br_valid = 1; br_lowconf = lc;
        @(negedge clk); br_valid = 0; br_lowconf = 0;
    endtask

    task automatic rename(input int pc, input bit dv, input int dst);
        @(negedge clk); ren_valid = 1; ren_pc = CW'(pc); ren_dst_valid = dv; ren_dst_areg = 3'(dst);
        @(negedge clk); ren_valid = 0; ren_dst_valid = 0;
    endtask

    task automatic resolve(input bit mis, input int age);
        @(negedge clk); resolve_valid = 1; resolve_mispred = mis; conv_age = AW'(age);
    endtask

    // after resolve: count stall/done cycles over a fixed window
    task automatic observe(output int n_st, output int n_dn, output int first_done);
        n_st = 0; n_dn = 0; first_done = -1;
        for (int c = 1; c <= 12; c++) begin
            @(negedge clk);
            resolve_valid = 0; resolve_mispred = 0;
            if (stall) n_st++;
            if (done) begin n_dn++; if (first_done < 0) first_done = c; end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            mismatched++; compared++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int base[8], wrong[8], fix[8];
        int ns, nd, fd;
        for (int i = 0; i < 8; i++) base[i] = i;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        cmp("R1", {63'd0, stall}, 64'd0);
        cmp("R1", {63'd0, done}, 64'd0);
        check_stores("R1");

        // load stores: two old IQ entries, two young; one young and one old checkpoint
        iq_put(0, 5, 10, 11, 0, 0);
        iq_put(1, 10, 10, 3, 1, 0);
        iq_put(2, 12, 11, 12, 0, 1);
        iq_put(3, 3, 11, 0, 0, 0);
        wrong = base; wrong[2] = 10; wrong[5] = 11; wrong[1] = 12; wrong[6] = 10;
        ck_put(0, 9, pack(wrong));
        ck_put(1, 4, pack(wrong));

        // ---- high-confidence branch: nothing happens ----
        cur_req = "R2";
        map_now = pack(wrong);
        branch(0);
        rename(16'h0010, 1, 2);
        rename(16'h0040, 1, 3);
        fix = wrong; fix[2] = 20;
        fix_map = pack(fix);
        resolve(1, 8);
        observe(ns, nd, fd);
        cmp("R2", 64'(ns), 0);
        cmp("R2", 64'(nd), 0);
        check_stores("R2");

        // ---- main recovery ----
        cur_req = "R9";
        map_now = pack(base);
        branch(1);
        rename(16'h0010, 1, 2);
        rename(16'h0014, 1, 5);
        rename(16'h0018, 1, 1);
        map_now = pack(wrong);
        rename(16'h0040, 1, 3);           // convergence: snapshot, own dst not tracked (R3)
        wrong[2] = 30; map_now = pack(wrong); // later map change must not leak (R3)
        rename(16'h0044, 1, 4);
        fix = base; fix[2] = 20; fix[5] = 21; fix[1] = 12; fix[3] = 23; fix[7] = 22;
        fix_map = pack(fix);
        resolve(1, 8);
        observe(ns, nd, fd);
        cmp("R9", 64'(ns), 2);            // r2 and r5 only (R4)
        cmp("R10", 64'(nd), 1);
        cmp("R10", 64'(fd), 3);           // stall cycles 1,2; done cycle 3
        check_stores("R5");
        iq_rd_idx = 1; #0.1;
        cmp("R5", 64'(iq_rd_src0), 20);
        cmp("R7", 64'(iq_rd_rdy0), 0);    // preg_ready[20] = 0
        iq_rd_idx = 2; #0.1;
        cmp("R5", 64'(iq_rd_src0), 21);
        cmp("R7", 64'(iq_rd_rdy0), 1);    // preg_ready[21] = 1
        cmp("R4", 64'(iq_rd_src1), 12);   // r1 unchanged
        iq_rd_idx = 0; #0.1;
        cmp("R6", 64'(iq_rd_src0), 10);
        cmp("R6", 64'(iq_rd_src1), 11);
        ck_rd_idx = 0; #0.1;
        cmp("R8", 64'(ck_rd_map[2*PW +: PW]), 20);
        cmp("R8", 64'(ck_rd_map[6*PW +: PW]), 20);
        cmp("R8", 64'(ck_rd_map[5*PW +: PW]), 21);
        cmp("R3", 64'(ck_rd_map[3*PW +: PW]), 3);
        ck_rd_idx = 1; #0.1;
        cmp("R6", 64'(ck_rd_map[2*PW +: PW]), 10);

        // ---- correct prediction ----
        cur_req = "R11";
        branch(1);
        rename(16'h0020, 1, 6);
        rename(16'h0040, 0, 0);
        fix = base; fix[6] = 25; fix_map = pack(fix);
        resolve(0, 8);
        observe(ns, nd, fd);
        cmp("R11", 64'(ns), 0);
        cmp("R11", 64'(nd), 0);
        check_stores("R11");

        // ---- mispredict, empty mask ----
        cur_req = "R12";
        map_now = pack(base);
        branch(1);
        rename(16'h0020, 1, 1);
        rename(16'h0040, 0, 0);
        fix = base; fix[4] = 26; fix_map = pack(fix);
        resolve(1, 8);
        observe(ns, nd, fd);
        cmp("R12", 64'(ns), 0);
        cmp("R12", 64'(nd), 1);
        cmp("R12", 64'(fd), 1);

        // ---- all registers changed: eight-cycle walk ----
        cur_req = "R9";
        iq_put(0, 20, 8, 9, 1, 1);
        iq_put(1, 21, 15, 12, 0, 0);
        iq_put(2, 2, 8, 15, 1, 0);
        iq_put(3, 30, 13, 14, 0, 1);
        for (int i = 0; i < 8; i++) begin wrong[i] = i + 8; fix[i] = i + 16; end
        ck_put(0, 25, pack(wrong));
        ck_put(1, 1, pack(wrong));
        map_now = pack(base);
        branch(1);
        for (int i = 0; i < 8; i++) rename(16'h0100 + i, 1, i);
        map_now = pack(wrong);
        rename(16'h0040, 1, 0);
        fix_map = pack(fix);
        resolve(1, 10);
        observe(ns, nd, fd);
        cmp("R9", 64'(ns), 8);
        cmp("R10", 64'(fd), 9);
        check_stores("R8");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule